// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns 8-bit or 9-bit characters into asynchronous NRZ frames on one output line. The host places a character in a holding register. The character moves into a separate shift register on a bit-rate tick, and then leaves the block least significant bit first. It is framed by a low start bit and one high stop bit. Because the holding register and the shift register are separate, the host can queue the next character while the current one is still on the line. Frames are sent back to back with no idle time between them.

An external divider supplies a one-cycle `baud_tick` pulse. Each tick ends the current bit time and starts the next one. The block has an enable that decides when new traffic may begin. It also has a drive-enable output that shows when the line is being actively driven, and a break request that holds the line low for whole frame lengths. Two status outputs tell the host when it may write and when everything has left the line.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1, `tx_done` is 1, and `txd_oe` equals `tx_en`.
- R2: Whenever no frame or break is in progress, `txd` is 1.
- R3: With `nine_bit`=0, a frame starts on the first tick at which `tx_en` is 1 and the holding register is full. The frame is a 0 start bit, then `wr_data[7:0]` with bit 0 first, then a 1 stop bit. Each bit lasts exactly one tick interval.
- R4: With `nine_bit`=1, the frame carries 9 data bits, `wr_data[8:0]`, with bit 0 first, between the start bit and the stop bit.
- R5: A write (`wr_en`=1) into an empty holding register is accepted, and `hold_empty` falls on the next cycle. `hold_empty` rises on the tick that moves the character into the shift register.
- R6: A write while `hold_empty`=0 is ignored. The queued character is sent unchanged, and no extra frame appears.
- R7: If the holding register is full when a stop bit ends, the next start bit begins on that same tick, with no idle bit.
- R8: `tx_done` is 1 only when no frame is in progress and the holding register is empty. It falls after an accepted write and rises on the tick that ends the last stop bit.
- R9: `txd_oe` is 1 while a frame or break is in progress, or while `tx_en` is 1, and is 0 otherwise.
- R10: If `tx_en` falls during a frame, that frame and any queued character still go out, after which `txd_oe` falls. While `tx_en` is 0 and the line is idle, no new frame starts, and a written character waits until `tx_en` returns.
- R11: While `brk_req` and `tx_en` are 1 at an idle tick, `txd` is held at 0 in units of 10 bit times (`nine_bit`=0) or 11 bit times (`nine_bit`=1). A further unit follows at once while `brk_req` stays 1. After the last unit, one high bit is sent before any other traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit-time boundary |
| tx_en | input | 1 | Allows new frames and breaks to start from idle |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| brk_req | input | 1 | Requests a break |
| wr_en | input | 1 | Writes `wr_data` into the holding register |
| wr_data | input | 9 | Character to queue; bit 8 is used only in 9-bit mode |
| hold_empty | output | 1 | Holding register can accept a write |
| tx_done | output | 1 | Line idle and nothing queued |
| txd | output | 1 | Serial output |
| txd_oe | output | 1 | Line is actively driven |

## Verification
The bench exercises the line with several kinds of traffic:
- Single 8-bit characters with mixed bit values prove the bit order and framing.
- Pairs written while the shift register is busy show whether any idle bit slips in at the frame boundary.
- A third write aimed at a full holding register shows whether writes to a full buffer are wrongly accepted.
- 9-bit characters with the top bit both set and clear separate the two frame lengths.
- Clearing the enable mid-frame, and then writing while it is low, separates "drain what is queued" from "start nothing new".
- Breaks of one unit and of two units check the unit length, the repeat, and the trailing high bit.

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              nine_bit,
  input  logic              brk_req,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              hold_empty,
  output logic              tx_done,
  output logic              txd,
  output logic              txd_oe
);
  localparam int SH_W  = CHAR_W + 2;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(SH_W);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SH_W - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  typedef enum logic [2:0] {A_NONE, A_SHIFT, A_BRK, A_STOP, A_LOAD, A_IDLE} act_t;

  logic [CHAR_W-1:0] hold;
  logic              hold_full;
  logic [SH_W-1:0]   sh, ld;
  logic [CNT_W-1:0]  cnt;
  logic              busy, in_brk;
  act_t              act;

  always_comb begin
    act = A_NONE;
    if (baud_tick) begin
      if (busy && cnt != ONE)                act = A_SHIFT;
      else if (busy && in_brk && brk_req)    act = A_BRK;
      else if (busy && in_brk)               act = A_STOP;
      else if (hold_full && (tx_en || busy)) act = A_LOAD;
      else if (brk_req && tx_en)             act = A_BRK;
      else if (busy)                         act = A_IDLE;
    end
  end

  always_comb begin
    ld = '1;
    ld[0] = 1'b0;
    for (int i = 0; i < CHAR_W; i++)
      if (nine_bit || i < CHAR_W - 1) ld[i+1] = hold[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '1;
      cnt    <= '0;
      busy   <= 1'b0;
      in_brk <= 1'b0;
    end else begin
      case (act)
        A_SHIFT: begin
          sh  <= {1'b1, sh[SH_W-1:1]};
          cnt <= cnt - ONE;
        end
        A_BRK: begin
          sh     <= '0;
          cnt    <= nine_bit ? LEN_LONG : LEN_SHORT;
          busy   <= 1'b1;
          in_brk <= 1'b1;
        end
        A_STOP: begin
          sh     <= '1;
          cnt    <= ONE;
          in_brk <= 1'b0;
        end
        A_LOAD: begin
          sh     <= ld;
          cnt    <= nine_bit ? LEN_LONG : LEN_SHORT;
          busy   <= 1'b1;
          in_brk <= 1'b0;
        end
        A_IDLE: begin
          sh   <= '1;
          cnt  <= '0;
          busy <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (act == A_LOAD) begin
      hold_full <= 1'b0;
    end else if (wr_en && !hold_full) begin
      hold      <= wr_data;
      hold_full <= 1'b1;
    end
  end

  assign txd        = sh[0];
  assign txd_oe     = busy | tx_en;
  assign hold_empty = ~hold_full;
  assign tx_done    = ~busy & ~hold_full;

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt != '0);
  a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && act != A_LOAD) |=> $stable(hold) && hold_full);
  a_r8_done_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd && hold_empty);
  a_r9_drive_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> txd_oe);
  a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_en) |=> !busy);
  a_r11_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_brk) |-> !txd);
endmodule

// File: tb/sim_uart_dbuf_tx.sv
module sim_uart_dbuf_tx;
  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic tx_en = 1'b0, nine_bit = 1'b0, brk_req = 1'b0, wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic hold_empty, tx_done, txd, txd_oe;

  int checks = 0, fails = 0, div = 0;
  string tag = "R1";
  bit exp_q[$];

  uart_dbuf_tx u0 (.clk, .rst_n, .baud_tick, .tx_en, .nine_bit, .brk_req,
    .wr_en, .wr_data, .hold_empty, .tx_done, .txd, .txd_oe);

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    div <= (div == TICK_DIV-1) ? 0 : div + 1;
    baud_tick <= (div == TICK_DIV-2);
  end

  task automatic check(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && baud_tick) begin
      #2;
      if (exp_q.size() != 0) begin
        automatic bit e = exp_q.pop_front();
        check(txd == e, {tag, " line bit"}, txd, e);
      end else
        check(txd == 1'b1, "R2 idle line", txd, 1);
    end
  end

  task automatic push_frame(input logic [8:0] d, input bit nb);
    exp_q.push_back(1'b0);
    for (int i = 0; i < (nb ? 9 : 8); i++) exp_q.push_back(d[i]);
    exp_q.push_back(1'b1);
  endtask

  task automatic after_tick();
    @(posedge clk iff baud_tick);
    @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk iff baud_tick);
    @(negedge clk);
  endtask

  task automatic write(input logic [8:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_room();
    while (!hold_empty) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    wait_ticks(1);
    check(tx_done == 1'b1, "R8 done after last stop", tx_done, 1);
    check(hold_empty == 1'b1, "R5 empty at end", hold_empty, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
    check(tx_done == 1'b1, "R1 tx_done", tx_done, 1);
    check(txd_oe == 1'b0, "R1 txd_oe", txd_oe, 0);
    tx_en = 1'b1;
    #1 check(txd_oe == 1'b1, "R9 oe follows enable", txd_oe, 1);

    tag = "R3";
    after_tick();
    write(9'h0A5); push_frame(9'h0A5, 0);
    check(hold_empty == 1'b0, "R5 write fills", hold_empty, 0);
    check(tx_done == 1'b0, "R8 done falls", tx_done, 0);
    wait_idle();

    tag = "R7";
    after_tick();
    write(9'h0C3); push_frame(9'h0C3, 0);
    wait_room();
    check(tx_done == 1'b0, "R8 busy not done", tx_done, 0);
    write(9'h03C); push_frame(9'h03C, 0);
    check(hold_empty == 1'b0, "R5 queued", hold_empty, 0);
    write(9'h0FF);
    check(hold_empty == 1'b0, "R6 full write ignored", hold_empty, 0);
    wait_idle();

    tag = "R4";
    nine_bit = 1'b1;
    after_tick();
    write(9'h1A5); push_frame(9'h1A5, 1);
    wait_room();
    write(9'h0F3); push_frame(9'h0F3, 1);
    wait_idle();
    nine_bit = 1'b0;

    tag = "R10";
    after_tick();
    write(9'h081); push_frame(9'h081, 0);
    wait_room();
    write(9'h042); push_frame(9'h042, 0);
    wait_ticks(2);
    tx_en = 1'b0;
    #1 check(txd_oe == 1'b1, "R9 oe held in frame", txd_oe, 1);
    wait_idle();
    check(txd_oe == 1'b0, "R10 released", txd_oe, 0);
    after_tick();
    write(9'h099);
    wait_ticks(15);
    check(hold_empty == 1'b0, "R10 char waits", hold_empty, 0);
    check(tx_done == 1'b0, "R10 not done", tx_done, 0);
    tx_en = 1'b1; push_frame(9'h099, 0);
    wait_idle();

    tag = "R11";
    after_tick();
    brk_req = 1'b1;
    for (int i = 0; i < 20; i++) exp_q.push_back(1'b0);
    exp_q.push_back(1'b1);
    wait_ticks(12);
    brk_req = 1'b0;
    wait_idle();

    nine_bit = 1'b1;
    after_tick();
    brk_req = 1'b1;
    for (int i = 0; i < 11; i++) exp_q.push_back(1'b0);
    exp_q.push_back(1'b1);
    wait_ticks(3);
    brk_req = 1'b0;
    wait_idle();
    wait_ticks(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule